// File: doc/BRIEF.md
# Hard-Wired Step-Sequenced Processor Control Unit

This block produces the datapath enables of a simple single-bus processor. A step counter moves forward one step per clock. Combinational decode logic turns the current step, the opcode held in the instruction register, the condition flags and a memory-complete handshake into one-hot enables. These enables drive the program counter, the memory address and data registers, the instruction register, the register file port, the adder, the temporary register and memory read and write.

Every instruction starts with the same three fetch steps and one decode step. After that the opcode chooses an execution tail whose length depends on the instruction. Four instructions are supported: load, add, store and a conditional branch by offset. When the last step of an instruction's own sequence completes, the counter wraps back to the first fetch step. On every memory step the counter waits, with its enables held, until memory reports completion.

Top module: `hwcu_hardwired_ctrl`

## Requirements
- R1: While `rst` is high, every enable output is 0. The first cycle after `rst` falls is fetch step 0.
- R2: Fetch is opcode-independent. Step 0 asserts `pc_out_o` and `mar_in_o`. Step 1 asserts `mem_rd_o` and `pc_inc_o`. Step 2 asserts `mdr_out_o` and `ir_in_o`.
- R3: Step 3 is the decode step. It asserts no enable.
- R4: Load (opcode 1) runs 7 steps. Step 4 asserts `reg_out_o` and `mar_in_o`. Step 5 asserts `mem_rd_o`. Step 6 asserts `mdr_out_o` and `reg_in_o`. Fetch step 0 follows.
- R5: Add (opcode 2) runs 8 steps. Step 4 asserts `reg_out_o` and `mar_in_o`. Step 5 asserts `mem_rd_o`. Step 6 asserts `mdr_out_o` and `alu_add_o`. Step 7 asserts `tmp_out_o` and `reg_in_o`. Step 0 follows.
- R6: Store (opcode 3) runs 7 steps. Step 4 asserts `reg_out_o` and `mar_in_o`. Step 5 asserts `reg_out_o` and `mdr_in_o`. Step 6 asserts `mem_wr_o`. Step 0 follows.
- R7: Branch (opcode 4) is taken when `flags_i[0]` is 1 during step 3. A taken branch asserts `pc_out_o` and `alu_add_o` at step 4, then `tmp_out_o` and `pc_in_o` at step 5, and then returns to step 0.
- R8: When `flags_i[0]` is 0 during step 3, a branch ends after decode. Step 0 follows step 3.
- R9: Any opcode other than 1 to 4 ends after step 3 with no enable asserted, and step 0 follows.
- R10: The memory steps are step 1, step 5 of load and add, and step 6 of store. On a memory step the counter holds, and the enables stay unchanged, for as long as `mem_done_i` is 0. It leaves the step on the clock at which `mem_done_i` is 1. On any other step `mem_done_i` has no effect.
- R11: `mem_rd_o` and `mem_wr_o` are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode_i | input | OPC_W (4) | Opcode field of the instruction register |
| flags_i | input | FLAG_W (4) | Condition flags |
| mem_done_i | input | 1 | Memory operation complete |
| pc_out_o | output | 1 | Drive PC onto the bus |
| pc_in_o | output | 1 | Load PC from the bus |
| pc_inc_o | output | 1 | Increment PC |
| mar_in_o | output | 1 | Load memory address register |
| mdr_in_o | output | 1 | Load memory data register from the bus |
| mdr_out_o | output | 1 | Drive memory data register onto the bus |
| ir_in_o | output | 1 | Load instruction register |
| reg_in_o | output | 1 | Write the selected general register |
| reg_out_o | output | 1 | Drive the selected general register onto the bus |
| alu_add_o | output | 1 | Adder performs an add |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| tmp_out_o | output | 1 | Drive the temporary result register onto the bus |

## Verification
The hardest states to reach from the ports are the late memory stalls, load or add at step 5 and store at step 6. To get there, the counter must first pass a fetch stall and a decode step with the opcode already valid, and then see `mem_done_i` low for several cycles. The bench runs every opcode value with every flag pattern, using zero, one or two wait cycles on every memory step. During fetch it drives the inverted opcode, and on non-memory steps it sometimes raises `mem_done_i`. This shows that fetch ignores the opcode and that completion matters only where a stall is defined. A reset applied in the middle of an add stall covers the return to step 0 from deep in a sequence.

// File: rtl/hwcu_pkg.sv
package hwcu_pkg;

   // Datapath enable bundle, one bit per control point.
   typedef struct packed {
      logic pc_out;
      logic pc_in;
      logic pc_inc;
      logic mar_in;
      logic mdr_in;
      logic mdr_out;
      logic ir_in;
      logic reg_in;
      logic reg_out;
      logic alu_add;
      logic mem_rd;
      logic mem_wr;
      logic tmp_out;
   } hwcu_ctl_t;

   localparam hwcu_ctl_t HWCU_CTL_IDLE = '0;

   // Execution class selected by the decode step.
   typedef enum logic [2:0] {
      SEQ_NONE   = 3'd0,
      SEQ_LOAD   = 3'd1,
      SEQ_ADD    = 3'd2,
      SEQ_STORE  = 3'd3,
      SEQ_BRANCH = 3'd4
   } hwcu_seq_e;

endpackage

// File: rtl/hwcu_opdec.sv
module hwcu_opdec
   import hwcu_pkg::*;
#(
   parameter int OPC_W     = 4,
   parameter int OP_LOAD   = 1,
   parameter int OP_ADD    = 2,
   parameter int OP_STORE  = 3,
   parameter int OP_BRANCH = 4
) (
   input  logic [OPC_W-1:0] opcode_i,
   output hwcu_seq_e        seq_o
);

   localparam logic [OPC_W-1:0] C_LOAD   = OPC_W'(OP_LOAD);
   localparam logic [OPC_W-1:0] C_ADD    = OPC_W'(OP_ADD);
   localparam logic [OPC_W-1:0] C_STORE  = OPC_W'(OP_STORE);
   localparam logic [OPC_W-1:0] C_BRANCH = OPC_W'(OP_BRANCH);

   always_comb begin
      seq_o = SEQ_NONE;
      if (opcode_i == C_LOAD) begin
         seq_o = SEQ_LOAD;
      end else if (opcode_i == C_ADD) begin
         seq_o = SEQ_ADD;
      end else if (opcode_i == C_STORE) begin
         seq_o = SEQ_STORE;
      end else if (opcode_i == C_BRANCH) begin
         seq_o = SEQ_BRANCH;
      end
   end

endmodule

// File: rtl/hwcu_cond.sv
module hwcu_cond #(
   parameter int FLAG_W      = 4,
   parameter int BR_FLAG_IDX = 0,
   parameter bit BR_ON_SET   = 1'b1
) (
   input  logic [FLAG_W-1:0] flags_i,
   output logic              taken_o
);

   logic sel_flag;
   logic unused_flags;

   assign sel_flag     = flags_i[BR_FLAG_IDX];
   assign unused_flags = ^flags_i;

   generate
      if (BR_ON_SET) begin : g_on_set
         assign taken_o = sel_flag;
      end else begin : g_on_clear
         assign taken_o = ~sel_flag;
      end
   endgenerate

endmodule

// File: rtl/hwcu_step_ctr.sv
module hwcu_step_ctr #(
   parameter int STEP_W      = 3,
   parameter bit MEM_WAIT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wait_req_i,
   input  logic              mem_done_i,
   input  logic              last_i,
   output logic [STEP_W-1:0] step_o
);

   logic [STEP_W-1:0] step_q;
   logic              stall;

   generate
      if (MEM_WAIT_EN) begin : g_wait
         assign stall = wait_req_i & ~mem_done_i;
      end else begin : g_nowait
         logic unused_wait;
         assign unused_wait = wait_req_i ^ mem_done_i;
         assign stall       = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         step_q <= '0;
      end else if (!stall) begin
         if (last_i) begin
            step_q <= '0;
         end else begin
            step_q <= step_q + STEP_W'(1);
         end
      end
   end

   assign step_o = step_q;

   AST_RST_TO_FETCH: assert property (@(posedge clk)
      rst |=> step_q == '0); // R1

   generate
      if (MEM_WAIT_EN) begin : g_hold_chk
         AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (wait_req_i && !mem_done_i) |=> $stable(step_q)); // R10
      end
   endgenerate

endmodule

// File: rtl/hwcu_ctl_gen.sv
module hwcu_ctl_gen
   import hwcu_pkg::*;
#(
   parameter int STEP_W = 3
) (
   input  logic [STEP_W-1:0] step_i,
   input  hwcu_seq_e         seq_i,
   input  logic              taken_i,
   output hwcu_ctl_t         ctl_o,
   output logic              wait_req_o,
   output logic              last_o
);

   localparam logic [STEP_W-1:0] T0 = STEP_W'(0);
   localparam logic [STEP_W-1:0] T1 = STEP_W'(1);
   localparam logic [STEP_W-1:0] T2 = STEP_W'(2);
   localparam logic [STEP_W-1:0] T3 = STEP_W'(3);
   localparam logic [STEP_W-1:0] T4 = STEP_W'(4);
   localparam logic [STEP_W-1:0] T5 = STEP_W'(5);
   localparam logic [STEP_W-1:0] T6 = STEP_W'(6);
   localparam logic [STEP_W-1:0] T7 = STEP_W'(7);

   logic [STEP_W-1:0] seq_end;
   logic              in_fetch;

   assign in_fetch = (step_i <= T3);

   // Final step of each execution class.
   always_comb begin
      case (seq_i)
         SEQ_LOAD:   seq_end = T6;
         SEQ_ADD:    seq_end = T7;
         SEQ_STORE:  seq_end = T6;
         SEQ_BRANCH: seq_end = taken_i ? T5 : T3;
         default:    seq_end = T3;
      endcase
   end

   assign last_o = (step_i >= seq_end);

   // Steps that wait on memory completion.
   always_comb begin
      wait_req_o = 1'b0;
      if (step_i == T1) begin
         wait_req_o = 1'b1;
      end else if (step_i == T5 && (seq_i == SEQ_LOAD || seq_i == SEQ_ADD)) begin
         wait_req_o = 1'b1;
      end else if (step_i == T6 && seq_i == SEQ_STORE) begin
         wait_req_o = 1'b1;
      end
   end

   // Enable generation.
   always_comb begin
      ctl_o = HWCU_CTL_IDLE;
      if (in_fetch) begin
         case (step_i)
            T0: begin
               ctl_o.pc_out = 1'b1;
               ctl_o.mar_in = 1'b1;
            end
            T1: begin
               ctl_o.mem_rd = 1'b1;
               ctl_o.pc_inc = 1'b1;
            end
            T2: begin
               ctl_o.mdr_out = 1'b1;
               ctl_o.ir_in   = 1'b1;
            end
            default: ;
         endcase
      end else begin
         case (seq_i)
            SEQ_LOAD: begin
               case (step_i)
                  T4: begin
                     ctl_o.reg_out = 1'b1;
                     ctl_o.mar_in  = 1'b1;
                  end
                  T5: ctl_o.mem_rd = 1'b1;
                  T6: begin
                     ctl_o.mdr_out = 1'b1;
                     ctl_o.reg_in  = 1'b1;
                  end
                  default: ;
               endcase
            end
            SEQ_ADD: begin
               case (step_i)
                  T4: begin
                     ctl_o.reg_out = 1'b1;
                     ctl_o.mar_in  = 1'b1;
                  end
                  T5: ctl_o.mem_rd = 1'b1;
                  T6: begin
                     ctl_o.mdr_out = 1'b1;
                     ctl_o.alu_add = 1'b1;
                  end
                  T7: begin
                     ctl_o.tmp_out = 1'b1;
                     ctl_o.reg_in  = 1'b1;
                  end
                  default: ;
               endcase
            end
            SEQ_STORE: begin
               case (step_i)
                  T4: begin
                     ctl_o.reg_out = 1'b1;
                     ctl_o.mar_in  = 1'b1;
                  end
                  T5: begin
                     ctl_o.reg_out = 1'b1;
                     ctl_o.mdr_in  = 1'b1;
                  end
                  T6: ctl_o.mem_wr = 1'b1;
                  default: ;
               endcase
            end
            SEQ_BRANCH: begin
               case (step_i)
                  T4: begin
                     ctl_o.pc_out  = 1'b1;
                     ctl_o.alu_add = 1'b1;
                  end
                  T5: begin
                     ctl_o.tmp_out = 1'b1;
                     ctl_o.pc_in   = 1'b1;
                  end
                  default: ;
               endcase
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      AST_DECODE_QUIET: assert (step_i != T3 || ctl_o == HWCU_CTL_IDLE); // R3
   end

endmodule

// File: rtl/hwcu_hardwired_ctrl.sv
module hwcu_hardwired_ctrl
   import hwcu_pkg::*;
#(
   parameter int OPC_W       = 4,
   parameter int FLAG_W      = 4,
   parameter int BR_FLAG_IDX = 0,
   parameter bit BR_ON_SET   = 1'b1,
   parameter bit MEM_WAIT_EN = 1'b1,
   parameter int MAX_STEPS   = 8,
   parameter int OP_LOAD     = 1,
   parameter int OP_ADD      = 2,
   parameter int OP_STORE    = 3,
   parameter int OP_BRANCH   = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [OPC_W-1:0]  opcode_i,
   input  logic [FLAG_W-1:0] flags_i,
   input  logic              mem_done_i,
   output logic              pc_out_o,
   output logic              pc_in_o,
   output logic              pc_inc_o,
   output logic              mar_in_o,
   output logic              mdr_in_o,
   output logic              mdr_out_o,
   output logic              ir_in_o,
   output logic              reg_in_o,
   output logic              reg_out_o,
   output logic              alu_add_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic              tmp_out_o
);

   localparam int STEP_W = $clog2(MAX_STEPS);

   // Elaboration-time parameter checks.
   generate
      if (MAX_STEPS < 8) begin : g_bad_steps
         $error("hwcu: MAX_STEPS must be at least 8");
      end
      if (BR_FLAG_IDX < 0 || BR_FLAG_IDX >= FLAG_W) begin : g_bad_flag
         $error("hwcu: BR_FLAG_IDX outside flag vector");
      end
      if (OPC_W < 3) begin : g_bad_opc
         $error("hwcu: OPC_W too narrow for four opcodes");
      end
      if (OP_LOAD == OP_ADD || OP_LOAD == OP_STORE || OP_LOAD == OP_BRANCH ||
          OP_ADD == OP_STORE || OP_ADD == OP_BRANCH || OP_STORE == OP_BRANCH) begin : g_bad_ops
         $error("hwcu: opcode values must be distinct");
      end
   endgenerate

   hwcu_seq_e         seq;
   logic              taken;
   logic [STEP_W-1:0] step;
   logic              wait_req;
   logic              last;
   hwcu_ctl_t         ctl_raw;
   hwcu_ctl_t         ctl;

   hwcu_opdec #(
      .OPC_W     (OPC_W),
      .OP_LOAD   (OP_LOAD),
      .OP_ADD    (OP_ADD),
      .OP_STORE  (OP_STORE),
      .OP_BRANCH (OP_BRANCH)
   ) opdec_i (
      .opcode_i (opcode_i),
      .seq_o    (seq)
   );

   hwcu_cond #(
      .FLAG_W      (FLAG_W),
      .BR_FLAG_IDX (BR_FLAG_IDX),
      .BR_ON_SET   (BR_ON_SET)
   ) cond_i (
      .flags_i (flags_i),
      .taken_o (taken)
   );

   hwcu_step_ctr #(
      .STEP_W      (STEP_W),
      .MEM_WAIT_EN (MEM_WAIT_EN)
   ) ctr_i (
      .clk        (clk),
      .rst        (rst),
      .wait_req_i (wait_req),
      .mem_done_i (mem_done_i),
      .last_i     (last),
      .step_o     (step)
   );

   hwcu_ctl_gen #(
      .STEP_W (STEP_W)
   ) gen_i (
      .step_i     (step),
      .seq_i      (seq),
      .taken_i    (taken),
      .ctl_o      (ctl_raw),
      .wait_req_o (wait_req),
      .last_o     (last)
   );

   assign ctl = rst ? HWCU_CTL_IDLE : ctl_raw;

   assign pc_out_o  = ctl.pc_out;
   assign pc_in_o   = ctl.pc_in;
   assign pc_inc_o  = ctl.pc_inc;
   assign mar_in_o  = ctl.mar_in;
   assign mdr_in_o  = ctl.mdr_in;
   assign mdr_out_o = ctl.mdr_out;
   assign ir_in_o   = ctl.ir_in;
   assign reg_in_o  = ctl.reg_in;
   assign reg_out_o = ctl.reg_out;
   assign alu_add_o = ctl.alu_add;
   assign mem_rd_o  = ctl.mem_rd;
   assign mem_wr_o  = ctl.mem_wr;
   assign tmp_out_o = ctl.tmp_out;

   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
      !(mem_rd_o && mem_wr_o)); // R11

   AST_IR_THEN_DECODE: assert property (@(posedge clk) disable iff (rst)
      ir_in_o |=> (ctl == HWCU_CTL_IDLE)); // R3

   AST_BR_SKIP: assert property (@(posedge clk) disable iff (rst)
      (step == STEP_W'(3) && opcode_i == OPC_W'(OP_BRANCH) &&
       flags_i[BR_FLAG_IDX] != BR_ON_SET) |=> step == '0); // R8

   AST_END_WRAPS: assert property (@(posedge clk) disable iff (rst)
      (last && !(wait_req && !mem_done_i && MEM_WAIT_EN)) |=> (pc_out_o && mar_in_o)); // R9

endmodule

// File: tb/hwcu_hardwired_ctrl_tb.sv
`timescale 1ns/1ps
module hwcu_hardwired_ctrl_tb_top;

   localparam int B_PCO = 12, B_PCI = 11, B_INC = 10, B_MAR = 9, B_MDI = 8,
                  B_MDO = 7, B_IRI = 6, B_RGI = 5, B_RGO = 4, B_ADD = 3,
                  B_RD = 2, B_WR = 1, B_TMP = 0;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] opcode_i = '0;
   logic [3:0] flags_i = '0;
   logic       mem_done_i = 1'b0;
   logic       pc_out_o, pc_in_o, pc_inc_o, mar_in_o, mdr_in_o, mdr_out_o,
               ir_in_o, reg_in_o, reg_out_o, alu_add_o, mem_rd_o, mem_wr_o, tmp_out_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   hwcu_hardwired_ctrl dut_i (
      .clk(clk), .rst(rst), .opcode_i(opcode_i), .flags_i(flags_i), .mem_done_i(mem_done_i),
      .pc_out_o(pc_out_o), .pc_in_o(pc_in_o), .pc_inc_o(pc_inc_o), .mar_in_o(mar_in_o),
      .mdr_in_o(mdr_in_o), .mdr_out_o(mdr_out_o), .ir_in_o(ir_in_o), .reg_in_o(reg_in_o),
      .reg_out_o(reg_out_o), .alu_add_o(alu_add_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
      .tmp_out_o(tmp_out_o)
   );

   function automatic logic [12:0] bits(input int a, input int b);
      logic [12:0] v = '0;
      v[a] = 1'b1;
      if (b >= 0) v[b] = 1'b1;
      return v;
   endfunction

   function automatic logic [12:0] actual();
      return {pc_out_o, pc_in_o, pc_inc_o, mar_in_o, mdr_in_o, mdr_out_o, ir_in_o,
              reg_in_o, reg_out_o, alu_add_o, mem_rd_o, mem_wr_o, tmp_out_o};
   endfunction

   function automatic int seq_len(input int op, input bit tk);
      case (op)
         1: return 7;
         2: return 8;
         3: return 7;
         4: return tk ? 6 : 4;
         default: return 4;
      endcase
   endfunction

   function automatic bit is_mem(input int op, input int k);
      return (k == 1) || (k == 5 && (op == 1 || op == 2)) || (k == 6 && op == 3);
   endfunction

   function automatic logic [12:0] exp_word(input int op, input int k);
      if (k == 0) return bits(B_PCO, B_MAR);
      if (k == 1) return bits(B_RD, B_INC);
      if (k == 2) return bits(B_MDO, B_IRI);
      if (k == 3) return '0;
      case (op)
         1: case (k) 4: return bits(B_RGO, B_MAR); 5: return bits(B_RD, -1);
                     default: return bits(B_MDO, B_RGI); endcase
         2: case (k) 4: return bits(B_RGO, B_MAR); 5: return bits(B_RD, -1);
                     6: return bits(B_MDO, B_ADD); default: return bits(B_TMP, B_RGI); endcase
         3: case (k) 4: return bits(B_RGO, B_MAR); 5: return bits(B_RGO, B_MDI);
                     default: return bits(B_WR, -1); endcase
         default: case (k) 4: return bits(B_PCO, B_ADD); default: return bits(B_TMP, B_PCI); endcase
      endcase
   endfunction

   function automatic string tag_of(input int op, input bit tk, input int k);
      if (k < 3) return "R2";
      if (k == 3) return "R3";
      case (op)
         1: return "R4";
         2: return "R5";
         3: return "R6";
         4: return tk ? "R7" : "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string tag, input logic [12:0] exp);
      logic [12:0] act = actual();
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: enables actual=%013b expected=%013b", tag, act, exp);
      end
      tests++;
      if (mem_rd_o && mem_wr_o) begin
         fails++;
         $display("FAIL R11: rd=%0b wr=%0b expected not both", mem_rd_o, mem_wr_o);
      end
   endtask

   task automatic step_cycle(input logic [3:0] op, input logic [3:0] fl, input bit md,
                             input string tag, input logic [12:0] exp);
      @(negedge clk);
      opcode_i   = op;
      flags_i    = fl;
      mem_done_i = md;
      #1;
      check(tag, exp);
   endtask

   string prev_tag = "R1";

   task automatic run_instr(input int op, input logic [3:0] fl, input int waits);
      bit tk = fl[0];
      int n  = seq_len(op, tk);
      for (int k = 0; k < n; k++) begin
         logic [3:0] opv = (k < 3) ? ~4'(op) : 4'(op);
         string tg = (k == 0) ? prev_tag : tag_of(op, tk, k);
         if (is_mem(op, k)) begin
            for (int w = 0; w < waits; w++)
               step_cycle(opv, fl, 1'b0, "R10", exp_word(op, k));
            step_cycle(opv, fl, 1'b1, tg, exp_word(op, k));
         end else begin
            step_cycle(opv, fl, (waits == 2), tg, exp_word(op, k));
         end
      end
      prev_tag = tag_of(op, tk, 4);
   endtask

   initial begin
      // R1: reset state
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         #1;
         check("R1", '0);
      end
      @(negedge clk);
      rst = 1'b0;
      #1;
      check("R1", bits(B_PCO, B_MAR));
      @(posedge clk);
      // Hold T1 with memory not ready, then step through
      step_cycle(4'hF, 4'h0, 1'b0, "R10", bits(B_RD, B_INC));
      step_cycle(4'hF, 4'h0, 1'b0, "R10", bits(B_RD, B_INC));
      step_cycle(4'hF, 4'h0, 1'b1, "R10", bits(B_RD, B_INC));
      step_cycle(4'hF, 4'h0, 1'b0, "R2", bits(B_MDO, B_IRI));
      step_cycle(4'h2, 4'h0, 1'b0, "R3", '0);
      step_cycle(4'h2, 4'h0, 1'b0, "R5", bits(B_RGO, B_MAR));
      step_cycle(4'h2, 4'h0, 1'b0, "R10", bits(B_RD, -1));
      // Reset during the add read stall
      @(negedge clk);
      rst = 1'b1;
      #1;
      check("R1", '0);
      @(negedge clk);
      rst = 1'b0;
      #1;
      check("R1", bits(B_PCO, B_MAR));
      @(posedge clk);
      // Continue from T1 of the instruction in flight as opcode 0 (ends at T3)
      for (int k = 1; k < 4; k++)
         step_cycle((k < 3) ? 4'hF : 4'h0, 4'h0, 1'b1, tag_of(0, 1'b0, k), exp_word(0, k));
      prev_tag = "R9";
      // Sweep every opcode, flag pattern and wait count
      for (int w = 0; w < 3; w++)
         for (int op = 0; op < 16; op++)
            for (int f = 0; f < 16; f++)
               run_instr(op, 4'(f), w);
      step_cycle(4'h0, 4'h0, 1'b1, prev_tag, bits(B_PCO, B_MAR));
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      for (int c = 0; c < 150000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule